// File: doc/BRIEF.md
# Priority Interrupt Selection Arbiter

This block picks, every clock cycle, the most urgent of 96 interrupt sources and decides whether that source should interrupt the processor. Each source brings an enable bit, a pending bit and an 8-bit priority. A source takes part only when it is both enabled and pending. A smaller priority number is more urgent, and on a tie the lower source number wins.

The winner then passes through two gates. First, its priority must not be numerically above the programmable priority mask; otherwise no interrupt is reported. Second, the request line to the processor is raised only if the winner is strictly more urgent than the interrupt now in service, whose priority arrives as a 9-bit running priority. A running priority of 0x100 means nothing is in service. Both a global enable and a processor-side enable must be set before anything is reported. When nothing is reported, the block shows the reserved ID 1023.

All three outputs are registered. They show the result for the inputs sampled at the previous rising clock edge. The surrounding logic holds the per-source state, handles acknowledge and completion, and feeds back the running priority.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While reset is high, and on the first edge after it, `irq_req` is 0, `pend_id` is 1023 and `pend_prio` is 0xFF.
- R2: A source with its enable bit or its pending bit clear never wins. When no source has both bits set, `pend_id` is 1023 and `irq_req` is 0.
- R3: Among qualifying sources, the one with the numerically smallest priority is reported.
- R4: Among qualifying sources that share the smallest priority, the lowest source number is reported.
- R5: If `dist_en` or `cpu_en` is 0, `pend_id` is 1023 and `irq_req` is 0.
- R6: A winner whose priority is greater than `prio_mask` is not reported: `pend_id` is 1023 and `irq_req` is 0. A winner whose priority equals the mask is reported.
- R7: `irq_req` is 1 exactly when a winner is reported and its priority is strictly less than `run_prio`. Equal priority does not raise the request. A `run_prio` of 0x100 lets any reported winner raise it.
- R8: The outputs change one clock edge after the inputs. Between edges they hold the result of the last edge.
- R9: `pend_prio` carries the reported winner's priority, or 0xFF while `pend_id` is 1023.
- R10: The mask is compared on all 10 bits, so any mask value of 0xFF or above lets every 8-bit priority through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dist_en | input | 1 | Global enable for forwarding |
| cpu_en | input | 1 | Processor-side enable for forwarding |
| src_enable | input | 96 | Per-source enable bits, bit k for source k |
| src_pending | input | 96 | Per-source pending bits, bit k for source k |
| src_prio | input | 768 | Per-source priorities, source k in bits [8k+7:8k] |
| prio_mask | input | 10 | Priority threshold; winners above it are dropped |
| run_prio | input | 9 | Priority of the interrupt in service, 0x100 when idle |
| irq_req | output | 1 | Interrupt request to the processor |
| pend_id | output | 10 | Reported winner ID, 1023 when none |
| pend_prio | output | 8 | Reported winner priority, 0xFF when none |

## Verification
The assertions compare registered outputs with inputs taken one cycle earlier through `$past`. This assumes the inputs are at known values on every edge after reset. The bench drives every input from time zero and changes inputs only on falling edges, so each rising edge samples a stable, defined set. The assertions also assume the running priority never exceeds 0x100. Both directed and random stimulus keep `run_prio` within 0 to 0x100.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;
  localparam int PRIO_W  = 8;
  localparam int ID_W    = 10;
  localparam int MASK_W  = 10;
  localparam int RUN_W   = PRIO_W + 1;
  localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } cand_t;
endpackage

// File: rtl/prio_pick2.sv
module prio_pick2
  import prio_sel_pkg::*;
(
  input  cand_t lo,
  input  cand_t hi,
  output cand_t win
);
  // lo always covers lower source numbers, so it keeps ties
  always_comb begin
    if (hi.valid && (!lo.valid || (hi.prio < lo.prio))) win = hi;
    else                                                 win = lo;
  end
endmodule

// File: rtl/prio_tree.sv
module prio_tree
  import prio_sel_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic [NUM_SRC-1:0]        qual,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output cand_t                     best
);
  localparam int LVLS   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
  localparam int LEAVES = 1 << LVLS;

  // heap layout: node 1 is the root, leaves start at LEAVES
  cand_t node [1:2*LEAVES-1];

  generate
    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
      if (k < NUM_SRC) begin : g_real
        assign node[LEAVES+k] = '{valid: qual[k],
                                  prio:  prio_flat[k*PRIO_W +: PRIO_W],
                                  id:    ID_W'(k)};
      end else begin : g_pad
        assign node[LEAVES+k] = '{valid: 1'b0,
                                  prio:  {PRIO_W{1'b1}},
                                  id:    NONE_ID};
      end
    end
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
      prio_pick2 u_pick (
        .lo  (node[2*n]),
        .hi  (node[2*n+1]),
        .win (node[n])
      );
    end
  endgenerate

  assign best = node[1];
endmodule

// File: rtl/prio_gate.sv
module prio_gate
  import prio_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dist_en,
  input  logic              cpu_en,
  input  cand_t             best,
  input  logic [MASK_W-1:0] prio_mask,
  input  logic [RUN_W-1:0]  run_prio,
  output logic              irq_req,
  output logic [ID_W-1:0]   pend_id,
  output logic [PRIO_W-1:0] pend_prio
);
  logic [MASK_W-1:0] best_wide;
  logic              fwd;
  logic              preempt;

  assign best_wide = {{(MASK_W-PRIO_W){1'b0}}, best.prio};
  assign fwd       = dist_en && cpu_en && best.valid && (best_wide <= prio_mask);
  assign preempt   = fwd && ({1'b0, best.prio} < run_prio);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      pend_id   <= NONE_ID;
      pend_prio <= {PRIO_W{1'b1}};
    end else begin
      irq_req   <= preempt;
      pend_id   <= fwd ? best.id   : NONE_ID;
      pend_prio <= fwd ? best.prio : {PRIO_W{1'b1}};
    end
  end

  // R5: either enable low silences the next result
  a_r5_enables_gate: assert property (@(posedge clk) disable iff (rst)
    !(dist_en && cpu_en) |=> (!irq_req && pend_id == NONE_ID));

  // R6: a reported winner never exceeds the mask seen at its edge
  a_r6_mask_bound: assert property (@(posedge clk) disable iff (rst)
    (pend_id != NONE_ID) |-> ({{(MASK_W-PRIO_W){1'b0}}, pend_prio} <= $past(prio_mask)));

  // R7: a request implies a reported winner strictly above the running level
  a_r7_req_has_winner: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (pend_id != NONE_ID && {1'b0, pend_prio} < $past(run_prio)));

  // R9: the idle ID pairs with the all-ones priority
  a_r9_idle_prio: assert property (@(posedge clk) disable iff (rst)
    (pend_id == NONE_ID) |-> (pend_prio == {PRIO_W{1'b1}}));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import prio_sel_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        dist_en,
  input  logic                        cpu_en,
  input  logic [NUM_SRC-1:0]          src_enable,
  input  logic [NUM_SRC-1:0]          src_pending,
  input  logic [NUM_SRC*PRIO_W-1:0]   src_prio,
  input  logic [MASK_W-1:0]           prio_mask,
  input  logic [RUN_W-1:0]            run_prio,
  output logic                        irq_req,
  output logic [ID_W-1:0]             pend_id,
  output logic [PRIO_W-1:0]           pend_prio
);
  logic [NUM_SRC-1:0] qual;
  cand_t              best;

  assign qual = src_enable & src_pending;

  prio_tree #(.NUM_SRC(NUM_SRC)) u_tree (
    .qual      (qual),
    .prio_flat (src_prio),
    .best      (best)
  );

  prio_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .dist_en   (dist_en),
    .cpu_en    (cpu_en),
    .best      (best),
    .prio_mask (prio_mask),
    .run_prio  (run_prio),
    .irq_req   (irq_req),
    .pend_id   (pend_id),
    .pend_prio (pend_prio)
  );

  // R2: with no qualifying source the next result is idle
  a_r2_none_qualify: assert property (@(posedge clk) disable iff (rst)
    (qual == '0) |=> (!irq_req && pend_id == NONE_ID));
endmodule

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;
  localparam int CLK_P = 10;
  localparam int NUM   = 96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dist_en = 1'b0;
  logic cpu_en  = 1'b0;
  logic [NUM-1:0] en_v = '0;
  logic [NUM-1:0] pd_v = '0;
  logic [7:0] prio_a [NUM];
  logic [NUM*8-1:0] prio_flat;
  logic [9:0] mask = 10'h0F0;
  logic [8:0] run  = 9'h100;
  logic irq_req;
  logic [9:0] pend_id;
  logic [7:0] pend_prio;
  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb
    for (int k = 0; k < NUM; k++) prio_flat[k*8 +: 8] = prio_a[k];

  irq_prio_arbiter #(.NUM_SRC(NUM)) uut (
    .clk(clk), .rst(rst), .dist_en(dist_en), .cpu_en(cpu_en),
    .src_enable(en_v), .src_pending(pd_v), .src_prio(prio_flat),
    .prio_mask(mask), .run_prio(run),
    .irq_req(irq_req), .pend_id(pend_id), .pend_prio(pend_prio));

  // behavioural scan from the requirements
  task automatic ref_calc(output logic e_req, output logic [9:0] e_id,
                          output logic [7:0] e_pr);
    int best_p = 256;
    int best_i = -1;
    for (int k = 0; k < NUM; k++)
      if (en_v[k] && pd_v[k] && int'(prio_a[k]) < best_p) begin
        best_p = int'(prio_a[k]);
        best_i = k;
      end
    e_req = 1'b0; e_id = 10'd1023; e_pr = 8'hFF;
    if (dist_en && cpu_en && best_i >= 0 && best_p <= int'(mask)) begin
      e_id = 10'(best_i);
      e_pr = 8'(best_p);
      e_req = (best_p < int'(run));
    end
  endtask

  task automatic compare(string tag, logic e_req, logic [9:0] e_id, logic [7:0] e_pr);
    checks++;
    if (irq_req !== e_req || pend_id !== e_id || pend_prio !== e_pr) begin
      failures++;
      $display("FAIL %s: got req=%0b id=%0d prio=%0h, expected req=%0b id=%0d prio=%0h",
               tag, irq_req, pend_id, pend_prio, e_req, e_id, e_pr);
    end
  endtask

  // inputs are set just after a falling edge; result appears after next rise
  task automatic step_check(string tag);
    logic e_req; logic [9:0] e_id; logic [7:0] e_pr;
    ref_calc(e_req, e_id, e_pr);
    @(posedge clk);
    @(negedge clk);
    compare(tag, e_req, e_id, e_pr);
  endtask

  task automatic clear_all();
    en_v = '0; pd_v = '0;
    for (int k = 0; k < NUM; k++) prio_a[k] = 8'hA0;
    dist_en = 1'b1; cpu_en = 1'b1; mask = 10'h0F0; run = 9'h100;
  endtask

  task automatic t_reset();
    @(negedge clk);
    compare("R1 during reset", 1'b0, 10'd1023, 8'hFF);
    rst = 1'b0;
    clear_all();
    en_v[3] = 1'b1; pd_v[3] = 1'b1; prio_a[3] = 8'h10;
    // outputs still at reset value before the first active edge
    compare("R1 before first edge", 1'b0, 10'd1023, 8'hFF);
    step_check("R1 first edge");
  endtask

  task automatic t_qualify();
    clear_all();
    en_v[7] = 1'b1; prio_a[7] = 8'h01;
    pd_v[9] = 1'b1; prio_a[9] = 8'h02;
    step_check("R2 enable-only and pending-only");
    compare("R2 idle", 1'b0, 10'd1023, 8'hFF);
    en_v[20] = 1'b1; pd_v[20] = 1'b1; prio_a[20] = 8'h80;
    step_check("R2 only full qualifier wins");
    compare("R2 id", 1'b1, 10'd20, 8'h80);
  endtask

  task automatic t_lowest_value();
    clear_all();
    en_v = '1;
    pd_v[2] = 1'b1;  prio_a[2]  = 8'h60;
    pd_v[50] = 1'b1; prio_a[50] = 8'h18;
    pd_v[95] = 1'b1; prio_a[95] = 8'h30;
    step_check("R3 smallest value");
    compare("R3 source 50", 1'b1, 10'd50, 8'h18);
    prio_a[95] = 8'h00;
    step_check("R3 top source at zero");
  endtask

  task automatic t_ties();
    clear_all();
    en_v = '1;
    pd_v[90] = 1'b1; prio_a[90] = 8'h20;
    pd_v[17] = 1'b1; prio_a[17] = 8'h20;
    pd_v[5]  = 1'b1; prio_a[5]  = 8'h20;
    step_check("R4 tie");
    compare("R4 lowest index", 1'b1, 10'd5, 8'h20);
  endtask

  task automatic t_enables();
    clear_all();
    en_v[40] = 1'b1; pd_v[40] = 1'b1; prio_a[40] = 8'h10;
    dist_en = 1'b0;
    step_check("R5 global enable low");
    dist_en = 1'b1; cpu_en = 1'b0;
    step_check("R5 cpu enable low");
    compare("R5 idle", 1'b0, 10'd1023, 8'hFF);
    cpu_en = 1'b1;
    step_check("R5 both high");
  endtask

  task automatic t_mask();
    clear_all();
    en_v[12] = 1'b1; pd_v[12] = 1'b1; prio_a[12] = 8'hF1;
    step_check("R6 above mask");
    compare("R6 dropped", 1'b0, 10'd1023, 8'hFF);
    prio_a[12] = 8'hF0;
    step_check("R6 equal mask");
    compare("R6 kept", 1'b1, 10'd12, 8'hF0);
    prio_a[12] = 8'hFF; mask = 10'h3FF;
    step_check("R10 wide mask");
    compare("R10 all-ones prio passes", 1'b1, 10'd12, 8'hFF);
    mask = 10'h100;
    step_check("R10 mask 0x100");
  endtask

  task automatic t_running();
    clear_all();
    en_v[30] = 1'b1; pd_v[30] = 1'b1; prio_a[30] = 8'h40;
    run = 9'h040;
    step_check("R7 equal running");
    compare("R7 no preempt", 1'b0, 10'd30, 8'h40);
    run = 9'h041;
    step_check("R7 strictly lower");
    compare("R7 preempt", 1'b1, 10'd30, 8'h40);
    run = 9'h100; mask = 10'h3FF; prio_a[30] = 8'hFF;
    step_check("R7 idle running");
    compare("R7 idle preempt", 1'b1, 10'd30, 8'hFF);
  endtask

  task automatic t_latency();
    logic o_req; logic [9:0] o_id; logic [7:0] o_pr;
    clear_all();
    en_v[60] = 1'b1; pd_v[60] = 1'b1; prio_a[60] = 8'h50;
    step_check("R8 setup");
    ref_calc(o_req, o_id, o_pr);
    en_v[61] = 1'b1; pd_v[61] = 1'b1; prio_a[61] = 8'h08;
    #(CLK_P/4);
    compare("R8 hold before edge", o_req, o_id, o_pr);
    step_check("R8 update after edge");
  endtask

  task automatic t_random();
    for (int it = 0; it < 400; it++) begin
      for (int k = 0; k < NUM; k++) begin
        en_v[k] = ($urandom_range(0, 3) != 0);
        pd_v[k] = ($urandom_range(0, 7) == 0);
        prio_a[k] = 8'($urandom_range(0, 15) * 16 + ((it % 3 == 0) ? 0 : $urandom_range(0, 15)));
      end
      dist_en = ($urandom_range(0, 9) != 0);
      cpu_en  = ($urandom_range(0, 9) != 0);
      mask    = 10'($urandom_range(0, 1023));
      run     = 9'($urandom_range(0, 256));
      step_check("R3 R4 R6 R7 R9 random");
    end
  endtask

  initial begin
    for (int k = 0; k < NUM; k++) prio_a[k] = 8'hA0;
    repeat (3) @(posedge clk);
    t_reset();
    t_qualify();
    t_lowest_value();
    t_ties();
    t_enables();
    t_mask();
    t_running();
    t_latency();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule